// File: doc/BRIEF.md
# Overlapping block reservoir buffer

This block is a reservoir between a slow sample source and a fast, continuously clocked processing pipeline. Samples arrive on a write strobe that may be unrelated in time to the read clock. Every accepted strobe is moved into the read clock domain and stored in a 1024-word ring of 32-bit entries. When a programmed number of new samples has arrived, the block replays a fixed-length window from the ring on consecutive read clock cycles. That window always ends with the samples just acquired. When the window is longer than the new-sample count, its leading part repeats older samples, so consecutive windows overlap, as windowed frequency-domain transforms need.

The read clock performs every RAM access. A write that becomes pending takes the RAM for one read cycle, and the window output pauses for that cycle. The active-low `dav_n` flag marks exactly the cycles in which a window word is on `rd_data`, so a downstream stage can use it directly as its load enable. A separate early-warning flag rises after its own programmable number of new samples, which gives the consumer time to get ready. The window length, the new-sample count and the warning point come from mode pins and a configuration word. All of these are captured only while reset is applied.

Top module: `ovlbuf_top`

## Requirements
- R1: While reset is applied, `dav_n` is 1 and `warn` and `rd_valid` are 0. `len_mode`, `new_mode`, `warn_mode` and `cfg_bus` are captured only during reset, and later changes on those pins do not change the behaviour.
- R2: Window length L is 1024 words when `len_mode`=0. When `len_mode`=1 it is (cfg_bus[4:0]+1)*32 words. Each window delivers exactly L words.
- R3: The new-sample count N is selected by `new_mode`: 2'b00 gives 1024, 2'b01 gives 512, 2'b10 gives 256, and 2'b11 gives (cfg_bus[9:5]+1)*32. A window is launched each time N further samples have been stored.
- R4: Samples are numbered from 0 in the order they are accepted after reset, on a ring of 1024 addresses. The window launched by sample c-1 carries samples c-L through c-1 in ascending order. The oldest (L-N) words come first and the N new words come last.
- R5: `rd_valid` is 1 and `dav_n` is 0 exactly in the cycles that present a window word. In every other cycle `rd_data` keeps the last word presented.
- R6: Each stored sample takes one read cycle. The cycle after a write is performed carries no window word, so a gap inside a window lasts exactly one cycle.
- R7: The warning count W is selected by `warn_mode`: 2'b00 gives 1024, 2'b01 gives 512, 2'b10 gives 256, and 2'b11 gives (cfg_bus[15:10]+1)*16. `warn` rises only on a write, once W samples have been stored since the last window launch. It stays high through the window it announces and falls when that window's last word is read, unless the next window's W samples have already arrived.
- R8: The warning count restarts at every window launch, so `warn` never rises when W exceeds N.
- R9: A strobe with `wr_en_n`=1 stores nothing, advances no count and launches no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Continuous read clock. All RAM accesses and flags use its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_strobe | input | 1 | Write strobe. Its rising edge samples `wr_en_n` and `wr_data`. It may be unrelated to `clk` |
| wr_en_n | input | 1 | Active-low write enable, sampled on the rising edge of the strobe |
| wr_data | input | 32 | Sample word |
| len_mode | input | 1 | Window length select, captured during reset |
| new_mode | input | 2 | New-sample count select, captured during reset |
| warn_mode | input | 2 | Warning threshold select, captured during reset |
| cfg_bus | input | 16 | Configuration word, captured during reset: [4:0] length groups, [9:5] new groups, [15:10] warning groups |
| rd_data | output | 32 | Window word. Holds its value outside valid cycles |
| rd_valid | output | 1 | High in cycles that present a window word |
| dav_n | output | 1 | Active-low data-valid flag, usable directly as a downstream load enable |
| warn | output | 1 | Early-warning flag for the next window |

## Verification
Assertions check every cycle that a performed write leaves the following cycle without a window word and that the warning flag never rises except on a write. They also check that a window starts only right after the write that completes its new-sample count, that a window ends only after exactly L reads, and that the captured configuration stays frozen once reset is released. The bench scenarios are needed to show the rest: that window contents follow the overlap order over several length and new-count settings, that every mode code decodes correctly, that the warning flag holds or clears at a window's end, that disabled strobes leave no trace, and that the output holds its value between valid cycles.

// File: rtl/ovlbuf_pkg.sv
package ovlbuf_pkg;

  // Size selector shared by the new-sample and warning thresholds.
  typedef enum logic [1:0] {
    SZ_FULL    = 2'b00,
    SZ_HALF    = 2'b01,
    SZ_QUARTER = 2'b10,
    SZ_CUSTOM  = 2'b11
  } size_sel_e;

  function automatic int unsigned size_pick(input size_sel_e sel,
                                            input int unsigned depth,
                                            input int unsigned custom);
    unique case (sel)
      SZ_FULL:    return depth;
      SZ_HALF:    return depth >> 1;
      SZ_QUARTER: return depth >> 2;
      default:    return custom;
    endcase
  endfunction

endpackage

// File: rtl/ovlbuf_wsync.sv
// Captures a strobed sample and hands a one-cycle request to the read clock.
module ovlbuf_wsync #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rstn_s,
  input  logic              wr_strobe,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_req,
  output logic [DATA_W-1:0] wr_word
);

  logic              tog_q;
  logic [DATA_W-1:0] hold_q;
  logic [2:0]        sync_q;

  // strobe domain: toggle per accepted strobe, data held for the read side
  always_ff @(posedge wr_strobe or negedge rst_n) begin
    if (!rst_n)        tog_q <= 1'b0;
    else if (!wr_en_n) tog_q <= ~tog_q;
  end

  always_ff @(posedge wr_strobe) begin
    if (!wr_en_n) hold_q <= wr_data;
  end

  // read domain: two-stage synchroniser plus edge stage
  always_ff @(posedge clk or negedge rstn_s) begin
    if (!rstn_s) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], tog_q};
  end

  assign wr_req  = sync_q[2] ^ sync_q[1];
  assign wr_word = hold_q;

endmodule

// File: rtl/ovlbuf_ram.sv
// Ring storage with a registered read port; read and write never share a cycle.
module ovlbuf_ram #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstn_s,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // output register holds its value when no read is issued
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

  always_ff @(posedge clk or negedge rstn_s) begin
    if (!rstn_s) rvalid <= 1'b0;
    else         rvalid <= re;
  end

endmodule

// File: rtl/ovlbuf_ctrl.sv
// Pointers, new-sample and warning counters, window sequencing.
module ovlbuf_ctrl
  import ovlbuf_pkg::*;
#(
  parameter int ADDR_W         = 10,
  parameter int LEN_GRAN_LOG2  = 5,
  parameter int WARN_GRAN_LOG2 = 4,
  localparam int LEN_F  = ADDR_W - LEN_GRAN_LOG2,
  localparam int WARN_F = ADDR_W - WARN_GRAN_LOG2,
  localparam int CFG_W  = 2 * LEN_F + WARN_F,
  localparam int CW     = ADDR_W + 1,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstn_s,
  input  logic              wr_req,
  input  logic              len_mode,
  input  logic [1:0]        new_mode,
  input  logic [1:0]        warn_mode,
  input  logic [CFG_W-1:0]  cfg_bus,
  output logic              ram_we,
  output logic [ADDR_W-1:0] waddr,
  output logic              ram_re,
  output logic [ADDR_W-1:0] raddr,
  output logic              warn
);

  // configuration captured while reset is held
  logic             len_mode_q;
  size_sel_e        new_sel_q, warn_sel_q;
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (!rstn_s) begin
      len_mode_q <= len_mode;
      new_sel_q  <= size_sel_e'(new_mode);
      warn_sel_q <= size_sel_e'(warn_mode);
      cfg_q      <= cfg_bus;
    end
  end

  logic [CW-1:0] len_words, new_words, warn_words;

  assign len_words  = len_mode_q ?
                      CW'((int'(cfg_q[LEN_F-1:0]) + 1) << LEN_GRAN_LOG2) : CW'(DEPTH);
  assign new_words  = CW'(size_pick(new_sel_q, DEPTH,
                      (int'(cfg_q[2*LEN_F-1:LEN_F]) + 1) << LEN_GRAN_LOG2));
  assign warn_words = CW'(size_pick(warn_sel_q, DEPTH,
                      (int'(cfg_q[CFG_W-1:2*LEN_F]) + 1) << WARN_GRAN_LOG2));

  logic [ADDR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0]     newc_q, newc_d, warnc_q, warnc_d, left_q, left_d;
  logic              act_q, act_d, warn_q, warn_d;
  logic              launch, warn_sat;

  assign ram_re   = act_q && !wr_req;
  assign ram_we   = wr_req;
  assign waddr    = wptr_q;
  assign raddr    = rptr_q;
  assign warn     = warn_q;
  assign launch   = wr_req && (newc_q + CW'(1) == new_words);
  assign warn_sat = (warnc_q == warn_words);

  always_comb begin
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    newc_d  = newc_q;
    warnc_d = warnc_q;
    left_d  = left_q;
    act_d   = act_q;
    warn_d  = warn_q;
    if (ram_re) begin
      rptr_d = rptr_q + ADDR_W'(1);
      left_d = left_q - CW'(1);
      if (left_q == CW'(1)) begin
        act_d  = 1'b0;
        warn_d = warn_sat;   // keep it only if the next window is already announced
      end
    end
    if (wr_req) begin
      wptr_d = wptr_q + ADDR_W'(1);
      if (!warn_sat && (warnc_q + CW'(1) == warn_words)) warn_d = 1'b1;
      if (launch) begin
        newc_d  = '0;
        warnc_d = '0;
        act_d   = 1'b1;
        rptr_d  = wptr_q + ADDR_W'(1) - len_words[ADDR_W-1:0];
        left_d  = len_words;
      end else begin
        newc_d  = newc_q + CW'(1);
        warnc_d = warn_sat ? warnc_q : warnc_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstn_s) begin
    if (!rstn_s) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      newc_q  <= '0;
      warnc_q <= '0;
      left_q  <= '0;
      act_q   <= 1'b0;
      warn_q  <= 1'b0;
    end else begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      newc_q  <= newc_d;
      warnc_q <= warnc_d;
      left_q  <= left_d;
      act_q   <= act_d;
      warn_q  <= warn_d;
    end
  end

  // independent tally of reads in the current window
  logic [CW-1:0] seen_q;
  always_ff @(posedge clk or negedge rstn_s) begin
    if (!rstn_s)     seen_q <= '0;
    else if (launch) seen_q <= '0;
    else if (ram_re) seen_q <= seen_q + CW'(1);
  end

  assert_block_len_R2: assert property (@(posedge clk) disable iff (!rstn_s)
    $fell(act_q) |-> (seen_q == len_words));

  assert_start_on_write_R3: assert property (@(posedge clk) disable iff (!rstn_s)
    $rose(act_q) |-> $past(wr_req));

  assert_warn_on_write_R7: assert property (@(posedge clk) disable iff (!rstn_s)
    $rose(warn_q) |-> $past(wr_req));

  assert_cfg_frozen_R1: assert property (@(posedge clk) disable iff (!rstn_s)
    rstn_s |=> ($stable(cfg_q) && $stable(len_mode_q) && $stable(new_sel_q)));

endmodule

// File: rtl/ovlbuf_top.sv
module ovlbuf_top #(
  parameter int DATA_W         = 32,
  parameter int ADDR_W         = 10,
  parameter int LEN_GRAN_LOG2  = 5,
  parameter int WARN_GRAN_LOG2 = 4,
  localparam int CFG_W = 2 * (ADDR_W - LEN_GRAN_LOG2) + (ADDR_W - WARN_GRAN_LOG2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_strobe,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              len_mode,
  input  logic [1:0]        new_mode,
  input  logic [1:0]        warn_mode,
  input  logic [CFG_W-1:0]  cfg_bus,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              dav_n,
  output logic              warn
);

  // reset asserted asynchronously, released on the read clock
  logic [1:0] rst_pipe_q;
  logic       rstn_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rstn_s = rst_pipe_q[1];

  logic              wr_req, ram_we, ram_re;
  logic [DATA_W-1:0] wr_word;
  logic [ADDR_W-1:0] waddr, raddr;

  ovlbuf_wsync #(.DATA_W(DATA_W)) u_wsync (
    .clk(clk), .rst_n(rst_n), .rstn_s(rstn_s),
    .wr_strobe(wr_strobe), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .wr_req(wr_req), .wr_word(wr_word)
  );

  ovlbuf_ctrl #(
    .ADDR_W(ADDR_W), .LEN_GRAN_LOG2(LEN_GRAN_LOG2), .WARN_GRAN_LOG2(WARN_GRAN_LOG2)
  ) u_ctrl (
    .clk(clk), .rstn_s(rstn_s), .wr_req(wr_req),
    .len_mode(len_mode), .new_mode(new_mode), .warn_mode(warn_mode), .cfg_bus(cfg_bus),
    .ram_we(ram_we), .waddr(waddr), .ram_re(ram_re), .raddr(raddr), .warn(warn)
  );

  ovlbuf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .rstn_s(rstn_s),
    .we(ram_we), .waddr(waddr), .wdata(wr_word),
    .re(ram_re), .raddr(raddr), .rdata(rd_data), .rvalid(rd_valid)
  );

  assign dav_n = ~rd_valid;

  assert_write_steals_R6: assert property (@(posedge clk) disable iff (!rstn_s)
    wr_req |=> !rd_valid);

endmodule

// File: tb/ovlbuf_top_tb.sv
module ovlbuf_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, wr_strobe, wr_en_n, len_mode;
  logic [31:0] wr_data;
  logic [1:0]  new_mode, warn_mode;
  logic [15:0] cfg_bus;
  logic [31:0] rd_data;
  logic        rd_valid, dav_n, warn;

  ovlbuf_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_en_n(wr_en_n),
    .wr_data(wr_data), .len_mode(len_mode), .new_mode(new_mode),
    .warn_mode(warn_mode), .cfg_bus(cfg_bus), .rd_data(rd_data),
    .rd_valid(rd_valid), .dav_n(dav_n), .warn(warn)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int blk, pos, cfg_l, cfg_n, gap_run, gaps, k;
  bit mon_on = 0, have_last, warn_seen, exp_warn;
  logic [31:0] last_word, seed;

  function automatic logic [31:0] pat(input int idx);
    return (32'(idx) * 32'h9E3779B1) ^ seed;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // window monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (warn) warn_seen = 1;
      chk(dav_n == !rd_valid, "R5", 32'(dav_n), 32'(!rd_valid));
      if (rd_valid) begin
        if (gap_run > 0) begin
          chk(gap_run == 1, "R6", 32'(gap_run), 32'd1);
          gaps++;
          gap_run = 0;
        end
        if (pos == 0) chk(warn == exp_warn, exp_warn ? "R7" : "R8", 32'(warn), 32'(exp_warn));
        k = (blk + 1) * cfg_n - cfg_l + pos;
        if (k >= 0) chk(rd_data == pat(k), "R4", rd_data, pat(k));
        last_word = rd_data;
        have_last = 1;
        pos++;
        if (pos == cfg_l) begin
          pos = 0;
          blk++;
        end
      end else begin
        if (pos > 0) gap_run++;
        if (have_last) chk(rd_data == last_word, "R5", rd_data, last_word);
      end
    end
  end

  task automatic wr(input logic [31:0] d, input logic en_n);
    #3;
    wr_en_n = en_n;
    wr_data = d;
    #7  wr_strobe = 1'b1;
    #20 wr_strobe = 1'b0;
    #30;
  endtask

  task automatic run_cfg(input logic lm, input logic [1:0] nm, input logic [1:0] wm,
                         input logic [15:0] cf, input int len_w, input int new_w,
                         input int warn_w, input int nblk, input bit disabled_test);
    mon_on = 0;
    rst_n = 1'b0;
    len_mode = lm; new_mode = nm; warn_mode = wm; cfg_bus = cf;
    repeat (4) @(negedge clk);
    chk(dav_n == 1'b1, "R1", 32'(dav_n), 32'd1);
    chk(warn == 1'b0, "R1", 32'(warn), 32'd0);
    chk(rd_valid == 1'b0, "R1", 32'(rd_valid), 32'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // scrambled pins after reset must not matter (R1)
    len_mode = ~lm; new_mode = ~nm; warn_mode = ~wm; cfg_bus = ~cf;
    blk = 0; pos = 0; gap_run = 0; gaps = 0; have_last = 0; warn_seen = 0;
    cfg_l = len_w; cfg_n = new_w; exp_warn = (warn_w <= new_w);
    seed = {cf, 16'h3C5A};
    mon_on = 1;
    for (int i = 0; i < nblk * new_w; i++) begin
      if (disabled_test && (i % 8 == 3)) wr(32'hDEADBEEF, 1'b1);
      wr(pat(i), 1'b0);
    end
    repeat (1500) @(negedge clk);
    chk(blk == nblk, "R1 R2 R3 window count", 32'(blk), 32'(nblk));
    chk(pos == 0, "R2 window length", 32'(pos), 32'd0);
    chk(dav_n == 1'b1, "R5 idle", 32'(dav_n), 32'd1);
    chk(warn == 1'b0, "R7 cleared", 32'(warn), 32'd0);
    chk(gaps > 0, "R6 gaps seen", 32'(gaps), 32'd1);
    if (!exp_warn) chk(!warn_seen, "R8 never", 32'(warn_seen), 32'd0);
    if (disabled_test) begin
      for (int j = 0; j < 2 * new_w; j++) wr(32'hBAD0_0000 + 32'(j), 1'b1);
      repeat (400) @(negedge clk);
      chk(blk == nblk && pos == 0, "R9 no window", 32'(blk), 32'(nblk));
      chk(warn == 1'b0 && !rd_valid, "R9 no flags", 32'(warn), 32'd0);
    end
    mon_on = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R4 watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_strobe = 1'b0; wr_en_n = 1'b1; wr_data = '0;
    len_mode = 1'b0; new_mode = 2'b00; warn_mode = 2'b00; cfg_bus = '0;
    // L=1024, N=1024, W=512: no overlap
    run_cfg(1'b0, 2'b00, 2'b01, 16'h0000, 1024, 1024, 512, 2, 1'b0);
    // L=(7+1)*32, N=(1+1)*32, W=(2+1)*16, with disabled strobes interleaved
    run_cfg(1'b1, 2'b11, 2'b11, {6'd2, 5'd1, 5'd7}, 256, 64, 48, 6, 1'b1);
    // L=32, N=32, W=256 > N: warning never
    run_cfg(1'b1, 2'b11, 2'b10, {6'd0, 5'd0, 5'd0}, 32, 32, 256, 4, 1'b0);
    // L=1024, N=256 (75 percent overlap), W=(7+1)*16
    run_cfg(1'b0, 2'b10, 2'b11, {6'd7, 5'd4, 5'd9}, 1024, 256, 128, 5, 1'b0);
    // L=(31+1)*32, N=512, W=1024 > N
    run_cfg(1'b1, 2'b01, 2'b00, {6'd5, 5'd3, 5'd31}, 1024, 512, 1024, 3, 1'b0);
    finish_run();
  end

endmodule